// File: doc/BRIEF.md
# Multi-Mode Ethernet Transmit Symbol Encoder

This block turns nibble-wide transmit frame data into a serial line symbol stream for one port of an Ethernet physical layer. It runs on a bit-rate clock and emits one line symbol per cycle. It tells the frame source when it takes a nibble by pulsing `nib_strobe`, which stands in for the transmit nibble clock. Three line modes are supported. Twisted-pair 100 Mb mode codes each nibble to a 5-bit code group, scrambles the serial bits, and drives a three-level MLT3 code. Fiber 100 Mb mode uses the same code groups without scrambling and drives two-level NRZI. 10 Mb mode sends each nibble as Manchester half-bit symbols.

In both 100 Mb modes the block frames packets by itself. It fills idle time with IDLE code groups, replaces the first two nibbles of a frame with the start delimiter pair, and appends the end delimiter pair after the last nibble. A bypass input removes the code-group mapping and the framing, so that raw 5-bit code groups pass straight from `txd` to the line. The mode and bypass inputs are static configuration: they may change only while reset is asserted.

Top module: `eth_tx_symbol_encoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `line_sym` is 00 and `nib_strobe` is low. The first `nib_strobe` comes in the 5th cycle after reset in 100 Mb modes and in the 8th cycle in 10 Mb mode.
- R2: `nib_strobe` is high for one cycle in every 5 in the 100 Mb modes (mode 0 and 1) and in every 8 in 10 Mb mode (mode 2). `tx_en`, `tx_er` and `txd` are sampled only at the rising edge where `nib_strobe` is high. The group taken there starts on the line in the next cycle.
- R3: In the 100 Mb modes with bypass low, `tx_en` sampled low outside a frame sends IDLE (11111). The first nibble taken with `tx_en` high is replaced by 11000, and the following nibble is replaced by 10001 whatever its value.
- R4: Later nibbles taken with `tx_en` high are mapped by the 4B5B table: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101. Each group is sent bit 0 first, where bit 0 is the rightmost digit as written.
- R5: When `tx_en` is sampled low during a frame, the group sent is 01101, then 00111, and after that IDLE.
- R6: In the 100 Mb modes, `tx_er` sampled high together with `tx_en` replaces the data group with 00100. When `tx_en` is low, `tx_er` has no effect.
- R7: With `bypass` high in the 100 Mb modes, `txd[4:0]` is sent unchanged when `tx_en` is high (00100 if `tx_er` is also high), and IDLE is sent when `tx_en` is low. No delimiters are inserted.
- R8: In mode 0, every serial bit is XORed with the key bit s[10]^s[8] of an 11-bit register s (polynomial x^11+x^9+1). Each cycle the register shifts left with the key bit entering at s[0]. It is seeded with 0x5A5 on reset and holds its value in the other modes.
- R9: In mode 0, a 1 bit advances the line through the level sequence 0, +1, 0, -1 and a 0 bit holds the level. The codes are 00 for 0, 01 for +1 and 11 for -1, and the line never steps directly between +1 and -1.
- R10: In mode 1, `line_sym[0]` toggles on each 1 bit and holds on each 0 bit.
- R11: In mode 2, each `txd[3:0]` bit b (bit 0 first) is sent as ~b then b on `line_sym[0]`. When `tx_en` is sampled low the line stays low, and `tx_er` has no effect.
- R12: `line_sym` never takes the value 10, and in modes 1 and 2 `line_sym[1]` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Line mode: 0 twisted-pair 100 Mb, 1 fiber 100 Mb, 2 10 Mb |
| bypass | input | 1 | Send raw 5-bit code groups from txd |
| tx_en | input | 1 | Frame data valid |
| tx_er | input | 1 | Transmit error, substitutes the error group |
| txd | input | 5 | Nibble in bits 3:0; full code group when bypass is high |
| nib_strobe | output | 1 | High in the cycle whose rising edge takes the inputs |
| line_sym | output | 2 | Line symbol: 00/01/11 in mode 0, {0, level} otherwise |

## Verification
Some rules hold cycle by cycle and are checked by the bound assertions on every cycle: the strobe spacing for the selected mode, the illegal line code, the upper code bit staying clear in the two-level modes, and MLT3 never stepping directly between its two outer levels. Other behaviour depends on what was sampled several cycles earlier and on the running scrambler state. This covers delimiter insertion and removal, error substitution, bypass groups, the exact scrambled MLT3 sequence, NRZI toggling and Manchester half-bit order. Only the bench shows these, by comparing every cycle against its reference model across random frames in each mode and bypass setting.

// File: rtl/eth_tx_pkg.sv
`timescale 1ns/1ps
package eth_tx_pkg;

   typedef enum logic [1:0] {
      LM_TP100  = 2'd0,
      LM_FIB100 = 2'd1,
      LM_TP10   = 2'd2
   } line_mode_e;

   typedef enum logic [1:0] {
      FR_IDLE = 2'd0,
      FR_SSD2 = 2'd1,
      FR_DATA = 2'd2,
      FR_ESD2 = 2'd3
   } frame_state_e;

   localparam int CG_W  = 5;
   localparam int NIB_W = 4;

   localparam logic [CG_W-1:0] CG_IDLE = 5'b11111;
   localparam logic [CG_W-1:0] CG_SSD1 = 5'b11000;
   localparam logic [CG_W-1:0] CG_SSD2 = 5'b10001;
   localparam logic [CG_W-1:0] CG_ESD1 = 5'b01101;
   localparam logic [CG_W-1:0] CG_ESD2 = 5'b00111;
   localparam logic [CG_W-1:0] CG_ERR  = 5'b00100;

   function automatic logic [CG_W-1:0] nib_to_cg(input logic [NIB_W-1:0] n);
      logic [CG_W-1:0] c;
      case (n)
         4'h0: c = 5'b11110;
         4'h1: c = 5'b01001;
         4'h2: c = 5'b10100;
         4'h3: c = 5'b10101;
         4'h4: c = 5'b01010;
         4'h5: c = 5'b01011;
         4'h6: c = 5'b01110;
         4'h7: c = 5'b01111;
         4'h8: c = 5'b10010;
         4'h9: c = 5'b10011;
         4'hA: c = 5'b10110;
         4'hB: c = 5'b10111;
         4'hC: c = 5'b11010;
         4'hD: c = 5'b11011;
         4'hE: c = 5'b11100;
         default: c = 5'b11101;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/tx_group_framer.sv
`timescale 1ns/1ps
module tx_group_framer
   import eth_tx_pkg::*;
#(
   parameter int SER_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             mode_10,
   input  logic             bypass,
   input  logic             tx_en,
   input  logic             tx_er,
   input  logic [CG_W-1:0]  txd,
   output logic [SER_W-1:0] grp
);

   generate
      if (SER_W < CG_W || SER_W < 2*NIB_W) begin : g_bad_width
         $error("tx_group_framer: SER_W too small for a code group or a Manchester nibble");
      end
   endgenerate

   frame_state_e    st, st_nxt;
   logic [CG_W-1:0] cg;
   logic [SER_W-1:0] man;

   always_comb begin
      st_nxt = st;
      cg     = CG_IDLE;
      if (bypass) begin
         st_nxt = FR_IDLE;
         if (tx_en) cg = tx_er ? CG_ERR : txd;
      end else begin
         case (st)
            FR_IDLE: if (tx_en) begin
               cg     = CG_SSD1;
               st_nxt = FR_SSD2;
            end
            FR_SSD2: begin
               cg     = CG_SSD2;
               st_nxt = FR_DATA;
            end
            FR_DATA: if (tx_en) begin
               cg = tx_er ? CG_ERR : nib_to_cg(txd[NIB_W-1:0]);
            end else begin
               cg     = CG_ESD1;
               st_nxt = FR_ESD2;
            end
            default: begin
               cg     = CG_ESD2;
               st_nxt = FR_IDLE;
            end
         endcase
      end
   end

   always_comb begin
      man = '0;
      for (int i = 0; i < NIB_W; i++) begin
         man[2*i]   = tx_en & ~txd[i];
         man[2*i+1] = tx_en &  txd[i];
      end
   end

   assign grp = mode_10 ? man : {{(SER_W-CG_W){1'b0}}, cg};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                st <= FR_IDLE;
      else if (take && !mode_10) st <= st_nxt;
   end

endmodule

// File: rtl/tx_serializer.sv
`timescale 1ns/1ps
module tx_serializer #(
   parameter  int SER_W = 8,
   localparam int CNT_W = $clog2(SER_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] last_idx,
   input  logic [SER_W-1:0] load_val,
   output logic             strobe,
   output logic             bit_out
);

   logic [CNT_W-1:0] cnt;
   logic [SER_W-1:0] sh;

   assign strobe  = (cnt == last_idx);
   assign bit_out = sh[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         sh  <= '0;
      end else if (strobe) begin
         cnt <= '0;
         sh  <= load_val;
      end else begin
         cnt <= cnt + 1'b1;
         sh  <= sh >> 1;
      end
   end

endmodule

// File: rtl/tx_scrambler.sv
`timescale 1ns/1ps
module tx_scrambler #(
   parameter bit          ENABLE = 1'b1,
   parameter int          LEN    = 11,
   parameter int          TAP    = 9,
   parameter int unsigned SEED   = 32'h0000_05A5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv,
   output logic key
);

   generate
      if (ENABLE) begin : g_lfsr
         if (TAP < 1 || TAP >= LEN) begin : g_bad_tap
            $error("tx_scrambler: TAP must lie in 1..LEN-1");
         end
         if (SEED[LEN-1:0] == '0) begin : g_bad_seed
            $error("tx_scrambler: SEED must be nonzero");
         end
         logic [LEN-1:0] s;
         assign key = s[LEN-1] ^ s[TAP-1];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   s <= SEED[LEN-1:0];
            else if (adv) s <= {s[LEN-2:0], key};
         end
      end else begin : g_none
         assign key = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/tx_line_coder.sv
`timescale 1ns/1ps
module tx_line_coder
   import eth_tx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode,
   input  logic       bit_in,
   output logic [1:0] line_sym
);

   logic [1:0] phase;
   logic       nrzi_lvl;
   logic       man_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= 2'd0;
         nrzi_lvl <= 1'b0;
         man_lvl  <= 1'b0;
      end else begin
         case (mode)
            LM_TP100: phase    <= phase + {1'b0, bit_in};
            LM_TP10:  man_lvl  <= bit_in;
            default:  nrzi_lvl <= nrzi_lvl ^ bit_in;
         endcase
      end
   end

   always_comb begin
      case (mode)
         LM_TP100: case (phase)
            2'd1:    line_sym = 2'b01;
            2'd3:    line_sym = 2'b11;
            default: line_sym = 2'b00;
         endcase
         LM_TP10: line_sym = {1'b0, man_lvl};
         default: line_sym = {1'b0, nrzi_lvl};
      endcase
   end

endmodule

// File: rtl/eth_tx_symbol_encoder.sv
`timescale 1ns/1ps
module eth_tx_symbol_encoder
   import eth_tx_pkg::*;
#(
   parameter bit          SCRAMBLE = 1'b1,
   parameter int          SCR_LEN  = 11,
   parameter int          SCR_TAP  = 9,
   parameter int unsigned SCR_SEED = 32'h0000_05A5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode,
   input  logic       bypass,
   input  logic       tx_en,
   input  logic       tx_er,
   input  logic [4:0] txd,
   output logic       nib_strobe,
   output logic [1:0] line_sym
);

   localparam int SER_W   = 2*NIB_W;
   localparam int CNT_W   = $clog2(SER_W);
   localparam int LAST100 = CG_W - 1;
   localparam int LAST10  = SER_W - 1;

   logic             is_tp100, is_10;
   logic [CNT_W-1:0] last_idx;
   logic [SER_W-1:0] grp;
   logic             raw_bit, key, line_bit;

   assign is_tp100 = (mode == LM_TP100);
   assign is_10    = (mode == LM_TP10);
   assign last_idx = is_10 ? CNT_W'(LAST10) : CNT_W'(LAST100);

   tx_group_framer #(.SER_W(SER_W)) u_framer (
      .clk(clk), .rst_n(rst_n), .take(nib_strobe), .mode_10(is_10),
      .bypass(bypass), .tx_en(tx_en), .tx_er(tx_er), .txd(txd), .grp(grp)
   );

   tx_serializer #(.SER_W(SER_W)) u_ser (
      .clk(clk), .rst_n(rst_n), .last_idx(last_idx), .load_val(grp),
      .strobe(nib_strobe), .bit_out(raw_bit)
   );

   tx_scrambler #(.ENABLE(SCRAMBLE), .LEN(SCR_LEN), .TAP(SCR_TAP), .SEED(SCR_SEED)) u_scr (
      .clk(clk), .rst_n(rst_n), .adv(is_tp100), .key(key)
   );

   assign line_bit = raw_bit ^ (is_tp100 & key);

   tx_line_coder u_line (
      .clk(clk), .rst_n(rst_n), .mode(mode), .bit_in(line_bit), .line_sym(line_sym)
   );

endmodule

// File: rtl/tx_encoder_checks.sv
`timescale 1ns/1ps
module tx_encoder_checks
   import eth_tx_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] mode,
   input logic       nib_strobe,
   input logic [1:0] line_sym
);

   logic [3:0] gap;
   logic [3:0] gap_exp;

   assign gap_exp = (mode == LM_TP10) ? 4'd7 : 4'd4;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          gap <= '0;
      else if (nib_strobe) gap <= '0;
      else                 gap <= gap + 1'b1;
   end

   // R1 and R2: strobe spacing from reset onwards
   assert_strobe_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      nib_strobe |-> (gap == gap_exp));

   assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      nib_strobe |=> !nib_strobe);

   assert_code_legal_R12: assert property (@(posedge clk) disable iff (!rst_n)
      line_sym != 2'b10);

   assert_two_level_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != LM_TP100) |-> !line_sym[1]);

   assert_mlt3_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == LM_TP100) && $stable(mode) && ($past(line_sym) != 2'b00))
      |-> ((line_sym == $past(line_sym)) || (line_sym == 2'b00)));

endmodule

bind eth_tx_symbol_encoder tx_encoder_checks u_checks (
   .clk(clk), .rst_n(rst_n), .mode(mode), .nib_strobe(nib_strobe), .line_sym(line_sym)
);

// File: tb/eth_tx_symbol_encoder_bench.sv
`timescale 1ns/1ps
module eth_tx_symbol_encoder_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'd0;
   logic       bypass = 1'b0;
   logic       tx_en = 1'b0;
   logic       tx_er = 1'b0;
   logic [4:0] txd = '0;
   logic       nib_strobe;
   logic [1:0] line_sym;

   int n_checks = 0;
   int n_fail   = 0;
   string tag   = "R1";

   always #4 clk = ~clk;

   eth_tx_symbol_encoder u_eth_tx_symbol_encoder (
      .clk(clk), .rst_n(rst_n), .mode(mode), .bypass(bypass), .tx_en(tx_en),
      .tx_er(tx_er), .txd(txd), .nib_strobe(nib_strobe), .line_sym(line_sym)
   );

   // ---------------- reference model ----------------
   int         q[$];
   int         fstate;
   logic [10:0] lf;
   int         ph;
   bit         nz, lv;
   logic [1:0] exp_line;

   function automatic logic [4:0] ref_4b5b(input logic [3:0] n);
      logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                             5'b01010, 5'b01011, 5'b01110, 5'b01111,
                             5'b10010, 5'b10011, 5'b10110, 5'b10111,
                             5'b11010, 5'b11011, 5'b11100, 5'b11101};
      return t[n];
   endfunction

   function automatic void push_group();
      logic [4:0] cg;
      if (mode == 2'd2) begin
         for (int i = 0; i < 4; i++) begin
            q.push_back(tx_en ? int'(!txd[i]) : 0);
            q.push_back(tx_en ? int'(txd[i])  : 0);
         end
         return;
      end
      cg = 5'b11111;
      if (bypass) begin
         if (tx_en) cg = tx_er ? 5'b00100 : txd;
      end else begin
         case (fstate)
            0: if (tx_en) begin cg = 5'b11000; fstate = 1; end
            1: begin cg = 5'b10001; fstate = 2; end
            2: if (tx_en) cg = tx_er ? 5'b00100 : ref_4b5b(txd[3:0]);
               else begin cg = 5'b01101; fstate = 3; end
            default: begin cg = 5'b00111; fstate = 0; end
         endcase
      end
      for (int i = 0; i < 5; i++) q.push_back(int'(cg[i]));
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q.delete();
         for (int i = 0; i < ((mode == 2'd2) ? 8 : 5); i++) q.push_back(0);
         fstate = 0; lf = 11'h5A5; ph = 0; nz = 0; lv = 0; exp_line = 2'b00;
      end else begin
         int b;
         b = q.pop_front();
         if (mode == 2'd0) begin
            bit k;
            k  = lf[10] ^ lf[8];
            lf = {lf[9:0], k};
            if ((b ^ int'(k)) != 0) ph = (ph + 1) % 4;
            exp_line = (ph == 1) ? 2'b01 : (ph == 3) ? 2'b11 : 2'b00;
         end else if (mode == 2'd2) begin
            lv = (b != 0);
            exp_line = {1'b0, lv};
         end else begin
            if (b != 0) nz = !nz;
            exp_line = {1'b0, nz};
         end
         if (q.size() == 0) push_group();
      end
   end

   // ---------------- checking ----------------
   task automatic check(input string t, input string what, input int act, input int expv);
      n_checks++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", t, what, act, expv);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         check(tag, "line_sym", int'(line_sym), int'(exp_line));
         check(tag, "nib_strobe", int'(nib_strobe), int'(q.size() == 1));
         check("R12", "legal code", int'(line_sym == 2'b10 || (mode != 2'd0 && line_sym[1])), 0);
      end
   end

   task automatic do_reset(input logic [1:0] m, input logic byp);
      @(negedge clk);
      rst_n = 1'b0; mode = m; bypass = byp; tx_en = 1'b0; tx_er = 1'b0; txd = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic traffic(input int cycles, input int er_pct);
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk);
         if (($urandom % 40) == 0) tx_en = !tx_en;
         txd   = 5'($urandom);
         tx_er = (($urandom % 100) < er_pct);
      end
   endtask

   task automatic scenario(input logic [1:0] m, input logic byp, input int er_pct, input string t);
      tag = t;
      do_reset(m, byp);
      traffic(2000, er_pct);
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      // R1: reset state, and first strobe in 5th (100 Mb) / 8th (10 Mb) cycle
      @(negedge clk);
      check("R1", "line_sym in reset", int'(line_sym), 0);
      check("R1", "strobe in reset", int'(nib_strobe), 0);
      do_reset(2'd0, 1'b0);
      tag = "R1 R2";
      for (int i = 0; i < 5; i++) begin
         check("R1", "strobe after reset 100", int'(nib_strobe), int'(i == 4));
         @(negedge clk);
      end
      do_reset(2'd2, 1'b0);
      for (int i = 0; i < 8; i++) begin
         check("R1", "strobe after reset 10", int'(nib_strobe), int'(i == 7));
         @(negedge clk);
      end
      // directed: one-nibble frame in fiber mode (R3 R4 R5)
      do_reset(2'd1, 1'b0);
      tag = "R3 R4 R5 R10";
      @(posedge nib_strobe); @(negedge clk);
      tx_en = 1'b1; txd = 5'h0A;
      repeat (15) @(negedge clk);
      tx_en = 1'b0;
      repeat (40) @(negedge clk);
      // random scenarios against the model
      scenario(2'd1, 1'b0, 0,  "R2 R3 R4 R5 R10");
      scenario(2'd1, 1'b0, 15, "R6 R10");
      scenario(2'd1, 1'b1, 10, "R7 R10");
      scenario(2'd0, 1'b0, 0,  "R3 R8 R9");
      scenario(2'd0, 1'b0, 15, "R6 R8 R9");
      scenario(2'd0, 1'b1, 10, "R7 R8 R9");
      scenario(2'd2, 1'b0, 20, "R2 R11");
      scenario(2'd2, 1'b1, 20, "R11");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule